// File: doc/BRIEF.md
# Serial Queue Pointer Sequencer

This block sets the order in which a queued serial port steps through a 16-entry command and data queue. Software programs a start entry, an end entry, a wraparound choice and a finished-interrupt enable into a control word. It then sets a run bit. The sequencer presents the current queue entry to an external serializer. On every one-cycle transfer-done pulse it moves to the next entry.

When the end entry completes, the block raises a finished flag. It then either stops or wraps back, to entry zero or to the programmed start entry. While the sequencer runs, writes to the control word are held in a shadow buffer. The buffer is applied only at the next transfer boundary, and execution then restarts at the start entry of the new word. A second register holds the run bit, a loopback test control and the finished flag. It also reports the pointer of the last entry that completed.

Top module: `queue_ptr_seq`

## Requirements
- R1: After reset, `qAddr`, `qActive`, `loopBack` and `finIrq` are 0, and both registers read 0.
- R2: Control word (register address 0) fields are start entry [3:0], end entry [11:8], wrap-to [12], wrap enable [13] and finished-interrupt enable [14]. Other bits read 0. A read returns the applied word, never the pending one.
- R3: While `qActive` is 1, a control-word write is buffered. The applied word does not change until the next transfer-done pulse, and it changes on that pulse.
- R4: When a buffered word is applied at a transfer-done pulse and the sequencer does not stop, `qAddr` jumps to the start entry of the new word.
- R5: Writing the mode register (address 1) with run bit [0] = 1 while idle sets `qActive` and loads `qAddr` with the start entry. Writing run bit 0 stops the sequencer.
- R6: On a transfer-done pulse while active, when `qAddr` is not the end entry, `qAddr` advances by one modulo 16.
- R7: On a transfer-done pulse at the end entry with wraparound disabled, `qActive` falls and `qAddr` holds.
- R8: On a transfer-done pulse at the end entry with wraparound enabled, the sequencer stays active. `qAddr` becomes 0 when wrap-to is 0, and the start entry when wrap-to is 1.
- R9: The finished flag (mode bit [4]) is set when the end entry completes. A mode write with bit [4] = 0 clears it, and a mode write with bit [4] = 1 leaves it unchanged.
- R10: `finIrq` is 1 exactly while the finished flag and the interrupt-enable bit are both 1.
- R11: `loopBack` follows mode bit [1] from the cycle after the write.
- R12: Mode bits [11:8] read the queue entry that completed most recently.
- R13: A transfer-done pulse while idle changes neither `qAddr` nor any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 selects the control word, 1 selects the mode/status register |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for `regAddr` |
| xferDone | input | 1 | One-cycle pulse when the serializer finishes an entry |
| qAddr | output | 4 | Queue entry being executed |
| qActive | output | 1 | Sequencer is running |
| loopBack | output | 1 | Serializer feedback test enable |
| finIrq | output | 1 | Finished interrupt |

## Verification
The assertions assume that a register write never arrives in the same cycle as a transfer-done pulse. Under that assumption, the one-step pointer and stop properties hold without the software-priority cases. The bench drives writes and pulses in separate cycles, including in its random phase. A behavioural model follows every cycle, covering the pending buffer, wrap targets and the idle apply of a buffered word.

// File: rtl/queue_ptr_pkg.sv
package queue_ptr_pkg;
  localparam int REG_W      = 16;
  localparam int START_LSB  = 0;
  localparam int END_LSB    = 8;
  localparam int WRAPTO_BIT = 12;
  localparam int WRAPEN_BIT = 13;
  localparam int FINIE_BIT  = 14;
  localparam int RUN_BIT    = 0;
  localparam int LOOP_BIT   = 1;
  localparam int FIN_BIT    = 4;
  localparam int DONE_LSB   = 8;
  localparam logic REG_CTRL = 1'b0;
  localparam logic REG_MODE = 1'b1;

  typedef struct packed {
    logic directWr;
    logic bufWr;
    logic applyPend;
    logic startRun;
    logic restart;
    logic advance;
    logic wrapJump;
    logic capDone;
    logic setFin;
    logic modeWr;
  } seqStb_t;
endpackage

// File: rtl/queue_ptr_ctrl.sv
module queue_ptr_ctrl
  import queue_ptr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    regWrEn,
  input  logic    regAddr,
  input  logic    runBit,
  input  logic    xferDone,
  input  logic    atEnd,
  input  logic    wrapEn,
  output seqStb_t stb,
  output logic    active,
  output logic    pendValid
);
  logic ctlWr, doneAct, stopNow;

  always_comb begin
    ctlWr   = regWrEn & (regAddr == REG_CTRL);
    doneAct = xferDone & active;
    stopNow = doneAct & atEnd & ~wrapEn;
    stb.modeWr    = regWrEn & (regAddr == REG_MODE);
    stb.directWr  = ctlWr & ~active;
    stb.bufWr     = ctlWr & active;
    stb.applyPend = pendValid & (doneAct | ~active);
    stb.startRun  = stb.modeWr & runBit & ~active;
    stb.restart   = doneAct & pendValid & ~stopNow;
    stb.advance   = doneAct & ~atEnd & ~pendValid;
    stb.wrapJump  = doneAct & atEnd & wrapEn & ~pendValid;
    stb.capDone   = doneAct;
    stb.setFin    = doneAct & atEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      pendValid <= 1'b0;
    end else begin
      if (stb.modeWr)  active <= runBit;
      else if (stopNow) active <= 1'b0;
      if (stb.bufWr)          pendValid <= 1'b1;
      else if (stb.applyPend) pendValid <= 1'b0;
    end
  end
endmodule

// File: rtl/queue_ptr_dp.sv
module queue_ptr_dp
  import queue_ptr_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStb_t          stb,
  input  logic             active,
  input  logic             regAddr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic [REG_W-1:0] ctrlWord,
  output logic [PTR_W-1:0] qAddr,
  output logic             atEnd,
  output logic             wrapEn,
  output logic             finFlag,
  output logic             finIe,
  output logic             loopBack
);
  localparam logic [REG_W-1:0] PTR_ONES  = REG_W'((1 << PTR_W) - 1);
  localparam logic [REG_W-1:0] CTRL_MASK = (PTR_ONES << START_LSB) | (PTR_ONES << END_LSB)
                                         | (REG_W'(7) << WRAPTO_BIT);

  logic [REG_W-1:0] pendWord;
  logic [PTR_W-1:0] donePtr;
  logic [PTR_W-1:0] startPtr, endPtr, pendStart;

  assign startPtr  = ctrlWord[START_LSB +: PTR_W];
  assign endPtr    = ctrlWord[END_LSB +: PTR_W];
  assign pendStart = pendWord[START_LSB +: PTR_W];
  assign atEnd     = (qAddr == endPtr);
  assign wrapEn    = ctrlWord[WRAPEN_BIT];
  assign finIe     = ctrlWord[FINIE_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlWord <= '0;
      pendWord <= '0;
      qAddr    <= '0;
      donePtr  <= '0;
      finFlag  <= 1'b0;
      loopBack <= 1'b0;
    end else begin
      if (stb.applyPend) ctrlWord <= pendWord;
      if (stb.directWr)  ctrlWord <= regWrData & CTRL_MASK;
      if (stb.bufWr)     pendWord <= regWrData & CTRL_MASK;
      if (stb.startRun)      qAddr <= startPtr;
      else if (stb.restart)  qAddr <= pendStart;
      else if (stb.advance)  qAddr <= qAddr + 1'b1;
      else if (stb.wrapJump) qAddr <= ctrlWord[WRAPTO_BIT] ? startPtr : '0;
      if (stb.capDone) donePtr <= qAddr;
      if (stb.setFin) finFlag <= 1'b1;
      else if (stb.modeWr && !regWrData[FIN_BIT]) finFlag <= 1'b0;
      if (stb.modeWr) loopBack <= regWrData[LOOP_BIT];
    end
  end

  always_comb begin
    if (regAddr == REG_CTRL) begin
      regRdData = ctrlWord;
    end else begin
      regRdData = '0;
      regRdData[RUN_BIT]  = active;
      regRdData[LOOP_BIT] = loopBack;
      regRdData[FIN_BIT]  = finFlag;
      regRdData[DONE_LSB +: PTR_W] = donePtr;
    end
  end
endmodule

// File: rtl/queue_ptr_seq.sv
module queue_ptr_seq
  import queue_ptr_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regAddr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             xferDone,
  output logic [PTR_W-1:0] qAddr,
  output logic             qActive,
  output logic             loopBack,
  output logic             finIrq
);
  seqStb_t          stb;
  logic             atEnd, wrapEn, finFlag, finIe, pendValid;
  logic [REG_W-1:0] ctrlWord;

  queue_ptr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .runBit(regWrData[RUN_BIT]), .xferDone(xferDone), .atEnd(atEnd),
    .wrapEn(wrapEn), .stb(stb), .active(qActive), .pendValid(pendValid)
  );

  queue_ptr_dp #(.PTR_W(PTR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .active(qActive), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .ctrlWord(ctrlWord),
    .qAddr(qAddr), .atEnd(atEnd), .wrapEn(wrapEn), .finFlag(finFlag),
    .finIe(finIe), .loopBack(loopBack)
  );

  assign finIrq = finFlag & finIe;
endmodule

// File: rtl/queue_ptr_seq_chk.sv
module queue_ptr_seq_chk #(
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic             regAddr,
  input logic             xferDone,
  input logic [PTR_W-1:0] qAddr,
  input logic             qActive,
  input logic             finIrq,
  input logic             atEnd,
  input logic             wrapEn,
  input logic             pendValid,
  input logic             finFlag,
  input logic             finIe,
  input logic [15:0]      ctrlWord
);
  assert_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (qActive && xferDone && !atEnd && !pendValid && !regWrEn)
      |=> qAddr == PTR_W'($past(qAddr) + 1'b1));

  assert_stop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (qActive && xferDone && atEnd && !wrapEn && !regWrEn) |=> !qActive);

  assert_wrap_stays_R8: assert property (@(posedge clk) disable iff (!rstN)
    (qActive && xferDone && atEnd && wrapEn && !regWrEn) |=> qActive);

  assert_fin_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    (qActive && xferDone && atEnd) |=> finFlag);

  assert_irq_mask_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!finFlag || !finIe) |-> !finIrq);

  assert_buffered_R3: assert property (@(posedge clk) disable iff (!rstN)
    (qActive && regWrEn && regAddr == 1'b0 && !xferDone) |=> $stable(ctrlWord));

  assert_idle_hold_R13: assert property (@(posedge clk) disable iff (!rstN)
    (!qActive && !regWrEn) |=> $stable(qAddr));
endmodule

bind queue_ptr_seq queue_ptr_seq_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .xferDone(xferDone), .qAddr(qAddr), .qActive(qActive), .finIrq(finIrq),
  .atEnd(atEnd), .wrapEn(wrapEn), .pendValid(pendValid), .finFlag(finFlag),
  .finIe(finIe), .ctrlWord(ctrlWord)
);

// File: tb/queue_ptr_seq_test.sv
`timescale 1ns/1ps
module queue_ptr_seq_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regAddr = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        xferDone = 1'b0;
  logic [3:0]  qAddr;
  logic        qActive, loopBack, finIrq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  queue_ptr_seq uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .xferDone(xferDone),
    .qAddr(qAddr), .qActive(qActive), .loopBack(loopBack), .finIrq(finIrq)
  );

  // behavioural reference model
  int mAct, mAddr, mCtrl, mPend, mPendV, mDone, mFin, mLoop;

  function automatic int modelRead(input int a);
    if (a == 0) return mCtrl;
    return mAct | (mLoop << 1) | (mFin << 4) | (mDone << 8);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mAct = 0; mAddr = 0; mCtrl = 0; mPend = 0; mPendV = 0;
      mDone = 0; mFin = 0; mLoop = 0;
    end else begin
      int d, nAct, nAddr, nCtrl, nPend, nPendV, nDone, nFin, nLoop;
      bit ctlWr, modeWr, doneAct, atEnd, stopIt, wEn;
      d = int'(regWrData);
      ctlWr   = regWrEn && regAddr == 1'b0;
      modeWr  = regWrEn && regAddr == 1'b1;
      doneAct = xferDone && mAct != 0;
      atEnd   = mAddr == ((mCtrl >> 8) & 15);
      wEn     = ((mCtrl >> 13) & 1) != 0;
      stopIt  = doneAct && atEnd && !wEn;
      nAct = mAct; nAddr = mAddr; nCtrl = mCtrl; nPend = mPend; nPendV = mPendV;
      nDone = mDone; nFin = mFin; nLoop = mLoop;
      if (mPendV != 0 && (doneAct || mAct == 0)) begin nCtrl = mPend; nPendV = 0; end
      if (ctlWr) begin
        if (mAct != 0) begin nPend = d & 'h7F0F; nPendV = 1; end
        else nCtrl = d & 'h7F0F;
      end
      if (modeWr && (d & 1) != 0 && mAct == 0) nAddr = mCtrl & 15;
      if (doneAct) begin
        nDone = mAddr;
        if (mPendV != 0 && !stopIt) nAddr = mPend & 15;
        else if (mPendV == 0 && !atEnd) nAddr = (mAddr + 1) % 16;
        else if (mPendV == 0 && wEn) nAddr = ((mCtrl >> 12) & 1) != 0 ? (mCtrl & 15) : 0;
      end
      if (modeWr) nAct = d & 1;
      else if (stopIt) nAct = 0;
      if (doneAct && atEnd) nFin = 1;
      else if (modeWr && (d & 'h10) == 0) nFin = 0;
      if (modeWr) nLoop = (d >> 1) & 1;
      mAct = nAct; mAddr = nAddr; mCtrl = nCtrl; mPend = nPend; mPendV = nPendV;
      mDone = nDone; mFin = nFin; mLoop = nLoop;
    end
    #2;
    if (rstN && !finished) begin
      chk("R6 qAddr", int'(qAddr), mAddr);
      chk("R7 qActive", int'(qActive), mAct);
      chk("R11 loopBack", int'(loopBack), mLoop);
      chk("R10 finIrq", int'(finIrq), mFin & ((mCtrl >> 14) & 1));
      chk("R2 regRdData", int'(regRdData), modelRead(int'(regAddr)));
    end
  end

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk); xferDone = 1'b1;
    @(negedge clk); xferDone = 1'b0;
  endtask

  task automatic rd(input logic a, output int v);
    regAddr = a; #1; v = int'(regRdData);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 qAddr", int'(qAddr), 0);
    chk("R1 qActive", int'(qActive), 0);
    chk("R1 finIrq", int'(finIrq), 0);
    rd(1'b1, v); chk("R1 mode read", v, 0);
    // R2 field layout and masking
    wr(1'b0, 16'hC502);
    rd(1'b0, v); chk("R2 ctrl read", v, 'h4502);
    // R13 pulse while idle
    pulse();
    chk("R13 qAddr idle", int'(qAddr), 0);
    rd(1'b1, v); chk("R13 flags idle", v, 0);
    // R5 start, R11 loopback
    wr(1'b1, 16'h0003);
    chk("R5 active", int'(qActive), 1);
    chk("R5 start entry", int'(qAddr), 2);
    chk("R11 loopBack", int'(loopBack), 1);
    pulse();
    chk("R6 advance", int'(qAddr), 3);
    rd(1'b1, v); chk("R12 done pointer", (v >> 8) & 15, 2);
    pulse(); pulse();
    chk("R6 at end", int'(qAddr), 5);
    pulse();
    chk("R7 stopped", int'(qActive), 0);
    chk("R7 addr held", int'(qAddr), 5);
    chk("R10 irq", int'(finIrq), 1);
    rd(1'b1, v); chk("R12 done end", (v >> 8) & 15, 5);
    wr(1'b1, 16'h0012);
    rd(1'b1, v); chk("R9 write one keeps flag", (v >> 4) & 1, 1);
    wr(1'b1, 16'h0002);
    rd(1'b1, v); chk("R9 write zero clears", (v >> 4) & 1, 0);
    chk("R10 irq cleared", int'(finIrq), 0);
    // R8 wrap to zero, with R6 advance from entry 0
    wr(1'b0, 16'h2F0E);
    wr(1'b1, 16'h0001);
    chk("R5 start 14", int'(qAddr), 14);
    pulse(); pulse();
    chk("R8 wrap to zero", int'(qAddr), 0);
    chk("R8 still active", int'(qActive), 1);
    chk("R10 irq masked", int'(finIrq), 0);
    pulse();
    chk("R6 after wrap", int'(qAddr), 1);
    wr(1'b1, 16'h0000);
    chk("R5 run bit zero stops", int'(qActive), 0);
    // R3/R4 buffering and restart, R8 wrap to start
    wr(1'b0, 16'h3903);
    wr(1'b1, 16'h0001);
    pulse();
    chk("R6 3 to 4", int'(qAddr), 4);
    wr(1'b0, 16'h3807);
    rd(1'b0, v); chk("R3 still old word", v, 'h3903);
    chk("R3 addr unchanged", int'(qAddr), 4);
    pulse();
    rd(1'b0, v); chk("R3 applied at boundary", v, 'h3807);
    chk("R4 restart entry", int'(qAddr), 7);
    pulse(); pulse();
    chk("R8 wrap to start", int'(qAddr), 7);
    wr(1'b1, 16'h0000);
    // R6 modulo-16 rollover
    wr(1'b0, 16'h010E);
    wr(1'b1, 16'h0001);
    pulse(); pulse();
    chk("R6 modulo rollover", int'(qAddr), 0);
    pulse(); pulse();
    chk("R7 stop at 1", int'(qActive), 0);
    // random phase against the model
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom % 16;
      if (r < 6) pulse();
      else if (r == 6) wr(1'b1, 16'($urandom & 'h13));
      else if (r == 7) wr(1'b0, 16'($urandom));
      else begin @(negedge clk); regAddr = 1'($urandom); end
    end
    @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule